// File: doc/BRIEF.md
# Baud-rate periodic tick interrupt generator

This block turns the serial port's internal baud clock into a general-purpose periodic interrupt source. It counts enable pulses from a programmable clock divider, divides them by 16 to reach the baud rate used for framing, and then divides by a further 32 unless a rate-select bit bypasses that second stage. When the chosen count completes, it raises a level interrupt request towards an external interrupt controller. The controller's acknowledge clears the request, so software never has to clear it.

Software drives a timer enable bit and a rate-select bit through a write strobe. Both bits are cleared by the hardware reset and by a synchronous software reset. While the timer is enabled the rate-select bit is locked. The timer works without any serial pins being set up for serial use. The clock-enable pulse is an input here, because the divider that produces it belongs elsewhere.

Top module: `baud_tick_timer`

## Requirements
- R1: After hardware reset, `irq_req`, `tmr_en` and `fine_rate` are all 0.
- R2: With `fine_rate` = 1 and the timer enabled, `irq_req` rises in the cycle after every 16th `baud_pulse` cycle, counted from the moment of enable.
- R3: With `fine_rate` = 0 and the timer enabled, `irq_req` rises after every 512th `baud_pulse` cycle (16 x 32).
- R4: While `tmr_en` is 0, `baud_pulse` has no effect and `irq_req` stays 0.
- R5: A cycle with `irq_ack` = 1 and no terminal count clears a pending `irq_req` on the next edge.
- R6: If a terminal count coincides with `irq_ack`, `irq_req` stays 1.
- R7: Once raised, `irq_req` stays 1 until it is acknowledged, disabled or reset.
- R8: A write (`cfg_wr` = 1) loads `tmr_en` from `cfg_en`. It loads `fine_rate` from `cfg_fine` only when `tmr_en` is 0 before the write. Otherwise `fine_rate` keeps its value.
- R9: When `tmr_en` is 0, both prescaler counts return to zero and any pending request drops. A re-enabled timer therefore needs a full period again.
- R10: `soft_rst` = 1 clears `tmr_en`, `fine_rate`, `irq_req` and both counts on the next edge.
- R11: Cycles with `baud_pulse` = 0 do not advance the count, whatever the spacing of the pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous software reset |
| baud_pulse | input | 1 | Internal serial clock enable pulse |
| cfg_wr | input | 1 | Write strobe for the control bits |
| cfg_en | input | 1 | Timer enable value to write |
| cfg_fine | input | 1 | Rate-select value to write (1 = bypass the divide-by-32 stage) |
| irq_ack | input | 1 | Acknowledge from the interrupt controller |
| irq_req | output | 1 | Timer interrupt request level |
| tmr_en | output | 1 | Current timer enable |
| fine_rate | output | 1 | Current rate-select bit |

## Verification
The bench checks the request after every single pulse. It sweeps complete periods in both rates, with pulses both back to back and sparse, so a divider that is off by one fires a pulse early or late and is caught. It makes a terminal count coincide with an acknowledge: a design that lets the acknowledge win would lose that tick. It rewrites the rate select while the timer is enabled, and it re-enables after a partial count. A design that accepts the locked write would change period. A design that keeps the counts over a disable would fire before a full period. Software reset and disable are applied while a request is pending, and a stuck request shows up there.

// File: rtl/baud_tick_timer.sv
module baud_tick_timer #(
  parameter int PRE_DIV = 16,
  parameter int EXT_DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic baud_pulse,
  input  logic cfg_wr,
  input  logic cfg_en,
  input  logic cfg_fine,
  input  logic irq_ack,
  output logic irq_req,
  output logic tmr_en,
  output logic fine_rate
);
  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam int EW = (EXT_DIV > 1) ? $clog2(EXT_DIV) : 1;
  localparam logic [PW-1:0] PRE_TOP = PW'(PRE_DIV - 1);
  localparam logic [EW-1:0] EXT_TOP = EW'(EXT_DIV - 1);

  logic [PW-1:0] pre_cnt;
  logic [EW-1:0] ext_cnt;
  logic          pre_wrap, ext_wrap, tick;

  assign pre_wrap = tmr_en && baud_pulse && (pre_cnt == PRE_TOP);
  assign ext_wrap = pre_wrap && (ext_cnt == EXT_TOP);
  assign tick     = fine_rate ? pre_wrap : ext_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_en    <= 1'b0;
      fine_rate <= 1'b0;
    end else if (soft_rst) begin
      tmr_en    <= 1'b0;
      fine_rate <= 1'b0;
    end else if (cfg_wr) begin
      tmr_en <= cfg_en;
      if (!tmr_en) fine_rate <= cfg_fine;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      ext_cnt <= '0;
    end else if (soft_rst || !tmr_en) begin
      pre_cnt <= '0;
      ext_cnt <= '0;
    end else if (baud_pulse) begin
      pre_cnt <= pre_wrap ? '0 : pre_cnt + 1'b1;
      if (pre_wrap && !fine_rate)
        ext_cnt <= ext_wrap ? '0 : ext_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   irq_req <= 1'b0;
    else if (soft_rst || !tmr_en) irq_req <= 1'b0;
    else if (tick)                irq_req <= 1'b1;
    else if (irq_ack)             irq_req <= 1'b0;
  end
endmodule

// File: rtl/baud_tick_timer_chk.sv
module baud_tick_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic soft_rst,
  input logic baud_pulse,
  input logic cfg_wr,
  input logic irq_ack,
  input logic irq_req,
  input logic tmr_en,
  input logic fine_rate
);
  a_r4_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_en |=> !irq_req);
  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack && !baud_pulse) |=> !irq_req);
  a_r7_level_held: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ack && tmr_en && !soft_rst && !cfg_wr) |=> irq_req);
  a_r8_rate_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_en && !soft_rst) |=> $stable(fine_rate));
  a_r10_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!tmr_en && !fine_rate && !irq_req));
  a_r11_rise_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_req && !baud_pulse) |=> !irq_req);
endmodule

bind baud_tick_timer baud_tick_timer_chk u_chk (.*);

// File: tb/sim_baud_tick_timer.sv
module sim_baud_tick_timer;
  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0, baud_pulse = 1'b0;
  logic cfg_wr = 1'b0, cfg_en = 1'b0, cfg_fine = 1'b0, irq_ack = 1'b0;
  logic irq_req, tmr_en, fine_rate;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  baud_tick_timer u0 (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write(input logic en, input logic fine);
    cfg_wr = 1'b1; cfg_en = en; cfg_fine = fine;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic pulse(input logic ack, input int gap);
    baud_pulse = 1'b1; irq_ack = ack;
    @(negedge clk);
    baud_pulse = 1'b0; irq_ack = 1'b0;
    idle(gap);
  endtask

  task automatic ack_now();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  // run one period, checking the request after every pulse
  task automatic period(input string req, input int len, input int gap);
    for (int k = 1; k <= len; k++) begin
      pulse(1'b0, gap);
      chk(req, irq_req, k == len);
    end
    ack_now();
    chk("R5", irq_req, 1'b0);
  endtask

  initial begin
    idle(3);
    chk("R1", irq_req, 1'b0); chk("R1", tmr_en, 1'b0); chk("R1", fine_rate, 1'b0);
    rst_n = 1'b1;
    idle(2);
    // R4: pulses while disabled do nothing
    for (int k = 0; k < 40; k++) pulse(1'b0, 0);
    chk("R4", irq_req, 1'b0);
    // R2: fine mode, back to back and sparse pulses (R11)
    write(1'b1, 1'b1);
    chk("R8", fine_rate, 1'b1);
    for (int p = 0; p < 3; p++) period("R2", 16, 0);
    period("R11", 16, 3);
    // R8: rate write while enabled is ignored
    write(1'b1, 1'b0);
    chk("R8", fine_rate, 1'b1);
    period("R8", 16, 1);
    // R6/R7: pending request, later tick coincident with ack
    for (int k = 0; k < 16; k++) pulse(1'b0, 0);
    idle(5);
    chk("R7", irq_req, 1'b1);
    for (int k = 0; k < 15; k++) pulse(1'b0, 0);
    pulse(1'b1, 0);
    chk("R6", irq_req, 1'b1);
    ack_now();
    chk("R5", irq_req, 1'b0);
    // R9: partial count then disable/re-enable restarts period
    for (int k = 0; k < 10; k++) pulse(1'b0, 0);
    write(1'b0, 1'b1);
    idle(1);
    for (int k = 0; k < 5; k++) pulse(1'b0, 0);
    chk("R4", irq_req, 1'b0);
    write(1'b1, 1'b1);
    period("R9", 16, 0);
    // R9: pending request dropped by disable
    for (int k = 0; k < 16; k++) pulse(1'b0, 0);
    chk("R7", irq_req, 1'b1);
    write(1'b0, 1'b1);
    idle(1);
    chk("R9", irq_req, 1'b0);
    // R3: coarse mode
    write(1'b0, 1'b0);
    write(1'b1, 1'b0);
    chk("R3", fine_rate, 1'b0);
    period("R3", 512, 0);
    period("R3", 512, 1);
    // R10: soft reset with request pending
    for (int k = 0; k < 512; k++) pulse(1'b0, 0);
    chk("R7", irq_req, 1'b1);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk("R10", irq_req, 1'b0); chk("R10", tmr_en, 1'b0); chk("R10", fine_rate, 1'b0);
    for (int k = 0; k < 20; k++) pulse(1'b0, 0);
    chk("R10", irq_req, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(100000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule